// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the front end of a transmit DMA engine. Software places 32-byte descriptors in a ring in memory. The first word of each descriptor is the buffer address, the next three words are configuration and the remaining 16 bytes are unused. Software gives a descriptor to hardware by clearing its ownership bit. The fetcher reads descriptors from the current ring position and turns each one it owns into a segment request for the data mover downstream. Once the mover accepts that request, the fetcher writes the configuration word back with the ownership bit set, which returns the slot to software.

There is no fixed ring length. A descriptor with the end-of-ring flag sends the next fetch back to the programmed base, and any other descriptor moves the pointer on by 32 bytes. A frame can span several descriptors: the first-segment and last-segment flags are passed downstream as start and end of packet. Software starts or restarts the walk with a kick pulse. It can pause the walk with a suspend level and can reload the ring position with an init pulse. When the fetcher reads a descriptor that software still owns, it stops and waits for the next kick.

All memory traffic goes through one request/grant port with a read-data valid strobe, and one request is outstanding at a time.

Top module: `txr_fetch`

## Requirements
- R1: After synchronous reset, mem_req and seg_valid are low and the fetcher is idle.
- R2: A walk begins by reading the configuration word at descriptor address + 4. If bit 31 (ownership) of that word is 1, the fetcher emits no segment, writes nothing, keeps its pointer and goes idle until a kick.
- R3: The segment request carries seg_addr = word at +0; seg_len = config bits 15:0; seg_csum = bits 18:16; seg_prio = bits 22:20; seg_force = bit 26; seg_pmap = bits 21:17 of the word at +8.
- R4: seg_sop equals config bit 29 (first segment) and seg_eop equals config bit 28 (last segment).
- R5: After the segment is accepted, the fetcher writes the configuration word back to address + 4 with bit 31 set and all other bits unchanged. Only then does it move to the next descriptor.
- R6: After the write-back, the pointer advances by 32 bytes, or returns to the ring base when config bit 30 (end of ring) was set.
- R7: An init pulse while idle loads both the ring base and the current pointer from ring_base, rounded down to a 32-byte boundary.
- R8: While suspend is high, no new descriptor is started. A descriptor already in progress completes its write-back, and the fetcher then halts.
- R9: The fetcher leaves idle only on a kick. A kick that arrives while the fetcher is busy or suspended is remembered and acted on once the fetcher is idle and not suspended.
- R10: A memory request holds its address, direction and data until granted. Read data is taken on mem_rvalid. At most one request is outstanding.
- R11: seg_valid and all segment fields stay stable until seg_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start/restart pulse |
| suspend | input | 1 | Hold off new descriptors while high |
| ring_init | input | 1 | Load base and pointer from ring_base (idle only) |
| ring_base | input | AW | Ring start address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Downstream accepts the segment |
| seg_addr | output | 32 | Segment buffer address |
| seg_len | output | 16 | Segment length in bytes |
| seg_csum | output | 3 | Checksum offload requests |
| seg_prio | output | 3 | Priority |
| seg_force | output | 1 | Force-route flag |
| seg_pmap | output | 5 | Destination port map |
| seg_sop | output | 1 | Start of packet |
| seg_eop | output | 1 | End of packet |

## Verification
The memory grant and seg_ready are both stalled in a pseudo-random pattern, so no result has a fixed latency. A segment is due only after three granted reads and their data strobes, and the write-back is due only after the segment handshake. The scoreboard therefore compares each segment at the cycle of its handshake, sampled on the falling edge, against a queue that holds descriptors in ring order. Results that depend on memory contents, stop conditions and halts are checked only after 40 consecutive cycles with neither a memory request nor a valid segment, which is longer than any gap the stall pattern can produce.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int DESC_BYTES = 32;
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);

    // configuration word bit positions
    localparam int B_OWN   = 31;
    localparam int B_WRAP  = 30;
    localparam int B_FIRST = 29;
    localparam int B_LAST  = 28;
    localparam int B_FORCE = 26;
    localparam int B_PRIO  = 20;
    localparam int B_CSUM  = 16;
    localparam int B_PMAP  = 17;   // in the second configuration word

    // descriptor word offsets
    localparam int OFS_BUFP = 0;
    localparam int OFS_CFG0 = 4;
    localparam int OFS_CFG1 = 8;

    // capture selectors
    localparam logic [1:0] CAP_CFG0 = 2'd0;
    localparam logic [1:0] CAP_BUFP = 2'd1;
    localparam logic [1:0] CAP_CFG1 = 2'd2;
    localparam int         NUM_CAP  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG0,
        ST_BUFP,
        ST_CFG1,
        ST_EMIT,
        ST_WBACK
    } fetch_st_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic [2:0]  csum;
        logic [2:0]  prio;
        logic        force_rt;
        logic [4:0]  pmap;
        logic        sop;
        logic        eop;
    } seg_t;

    function automatic seg_t unpack_desc(logic [31:0] bufp,
                                         logic [31:0] cfg0,
                                         logic [31:0] cfg1);
        seg_t s;
        s.addr     = bufp;
        s.len      = cfg0[15:0];
        s.csum     = cfg0[B_CSUM +: 3];
        s.prio     = cfg0[B_PRIO +: 3];
        s.force_rt = cfg0[B_FORCE];
        s.pmap     = cfg1[B_PMAP +: 5];
        s.sop      = cfg0[B_FIRST];
        s.eop      = cfg0[B_LAST];
        return s;
    endfunction

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] cur
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] base_aligned;

    assign base_aligned = {base_in[AW-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur    <= '0;
        end else if (load) begin
            base_q <= base_aligned;
            cur    <= base_aligned;
        end else if (adv) begin
            cur <= wrap ? base_q : cur + AW'(DESC_BYTES);
        end
    end

endmodule

// File: rtl/txr_desc_cap.sv
module txr_desc_cap
    import txr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_en,
    input  logic [1:0]  cap_sel,
    input  logic [31:0] rdata,
    output seg_t        seg,
    output logic [31:0] wb_word,
    output logic        wrap
);

    logic [31:0] words [NUM_CAP];

    for (genvar i = 0; i < NUM_CAP; i++) begin : g_word
        logic [31:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (cap_en && cap_sel == 2'(i))
                q <= rdata;
        end
        assign words[i] = q;
    end

    assign seg     = unpack_desc(words[CAP_BUFP], words[CAP_CFG0], words[CAP_CFG1]);
    assign wb_word = words[CAP_CFG0] | (32'd1 << B_OWN);
    assign wrap    = words[CAP_CFG0][B_WRAP];

endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    input  logic          suspend,
    input  logic          ring_init,
    input  logic [AW-1:0] cur_ptr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic          rd_own,
    input  logic          seg_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          cap_en,
    output logic [1:0]    cap_sel,
    output logic          ptr_load,
    output logic          ptr_adv,
    output logic          seg_valid
);

    fetch_st_t st;
    logic      issued;
    logic      kick_pend;
    logic      go;
    logic      rd_state;
    logic      rd_done;

    assign go       = (kick || kick_pend) && !suspend;
    assign rd_state = (st == ST_CFG0) || (st == ST_BUFP) || (st == ST_CFG1);
    assign rd_done  = rd_state && issued && mem_rvalid;

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = cur_ptr;
        cap_sel  = CAP_CFG0;
        unique case (st)
            ST_CFG0: begin
                mem_req  = !issued;
                mem_addr = cur_ptr + AW'(OFS_CFG0);
                cap_sel  = CAP_CFG0;
            end
            ST_BUFP: begin
                mem_req  = !issued;
                mem_addr = cur_ptr + AW'(OFS_BUFP);
                cap_sel  = CAP_BUFP;
            end
            ST_CFG1: begin
                mem_req  = !issued;
                mem_addr = cur_ptr + AW'(OFS_CFG1);
                cap_sel  = CAP_CFG1;
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_ptr + AW'(OFS_CFG0);
            end
            default: ;
        endcase
    end

    assign cap_en    = rd_done;
    assign seg_valid = (st == ST_EMIT);
    assign ptr_load  = (st == ST_IDLE) && ring_init;
    assign ptr_adv   = (st == ST_WBACK) && mem_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            issued    <= 1'b0;
            kick_pend <= 1'b0;
        end else begin
            if (st == ST_IDLE && go)
                kick_pend <= 1'b0;
            else if (kick)
                kick_pend <= 1'b1;

            if (rd_state && mem_req && mem_gnt)
                issued <= 1'b1;
            else if (rd_done)
                issued <= 1'b0;

            unique case (st)
                ST_IDLE:  if (go) st <= ST_CFG0;
                ST_CFG0:  if (rd_done) st <= rd_own ? ST_IDLE : ST_BUFP;
                ST_BUFP:  if (rd_done) st <= ST_CFG1;
                ST_CFG1:  if (rd_done) st <= ST_EMIT;
                ST_EMIT:  if (seg_ready) st <= ST_WBACK;
                ST_WBACK: if (mem_gnt) st <= suspend ? ST_IDLE : ST_CFG0;
                default:  st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    input  logic          suspend,
    input  logic          ring_init,
    input  logic [AW-1:0] ring_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          seg_valid,
    input  logic          seg_ready,
    output logic [31:0]   seg_addr,
    output logic [15:0]   seg_len,
    output logic [2:0]    seg_csum,
    output logic [2:0]    seg_prio,
    output logic          seg_force,
    output logic [4:0]    seg_pmap,
    output logic          seg_sop,
    output logic          seg_eop
);

    logic [AW-1:0] cur_ptr;
    logic          ptr_load;
    logic          ptr_adv;
    logic          wrap;
    logic          cap_en;
    logic [1:0]    cap_sel;
    seg_t          seg;
    logic [31:0]   wb_word;

    txr_ring_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (ptr_load),
        .base_in (ring_base),
        .adv     (ptr_adv),
        .wrap    (wrap),
        .cur     (cur_ptr)
    );

    txr_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .kick       (kick),
        .suspend    (suspend),
        .ring_init  (ring_init),
        .cur_ptr    (cur_ptr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .rd_own     (mem_rdata[B_OWN]),
        .seg_ready  (seg_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .cap_en     (cap_en),
        .cap_sel    (cap_sel),
        .ptr_load   (ptr_load),
        .ptr_adv    (ptr_adv),
        .seg_valid  (seg_valid)
    );

    txr_desc_cap u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_sel (cap_sel),
        .rdata   (mem_rdata),
        .seg     (seg),
        .wb_word (wb_word),
        .wrap    (wrap)
    );

    assign mem_wdata = wb_word;
    assign seg_addr  = seg.addr;
    assign seg_len   = seg.len;
    assign seg_csum  = seg.csum;
    assign seg_prio  = seg.prio;
    assign seg_force = seg.force_rt;
    assign seg_pmap  = seg.pmap;
    assign seg_sop   = seg.sop;
    assign seg_eop   = seg.eop;

endmodule

// File: rtl/txr_fetch_chk.sv
module txr_fetch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_gnt,
    input logic          seg_valid,
    input logic          seg_ready,
    input logic [31:0]   seg_addr,
    input logic [15:0]   seg_len,
    input logic [2:0]    seg_csum,
    input logic [2:0]    seg_prio,
    input logic          seg_force,
    input logic [4:0]    seg_pmap,
    input logic          seg_sop,
    input logic          seg_eop
);

    logic [61:0] seg_bus;
    assign seg_bus = {seg_addr, seg_len, seg_csum, seg_prio, seg_force,
                      seg_pmap, seg_sop, seg_eop};

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !mem_req && !seg_valid);

    assert_wb_owned_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata[31]);

    assert_word_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    assert_one_side_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && seg_valid));

    assert_seg_hold_R11: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_bus));

endmodule

bind txr_fetch txr_fetch_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_txr_fetch.sv
module sim_txr_fetch;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          kick = 1'b0;
    logic          suspend = 1'b0;
    logic          ring_init = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          seg_valid;
    logic          seg_ready = 1'b0;
    logic [31:0]   seg_addr;
    logic [15:0]   seg_len;
    logic [2:0]    seg_csum, seg_prio;
    logic          seg_force, seg_sop, seg_eop;
    logic [4:0]    seg_pmap;

    int nchk = 0;
    int nfail = 0;
    int seg_cnt = 0;
    int req_cnt = 0;
    logic [61:0] expq [$];
    logic [31:0] mem [0:1023];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    txr_fetch #(.AW(AW)) u0 (.*);

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and stall pattern
    always @(posedge clk) begin
        lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt    <= lfsr[0] | lfsr[3];
        seg_ready  <= lfsr[5] | lfsr[7];
        mem_rvalid <= !rst && mem_req && mem_gnt && !mem_we;
        mem_rdata  <= mem[mem_addr[11:2]];
        if (!rst && mem_req && mem_gnt && mem_we)
            mem[mem_addr[11:2]] <= mem_wdata;
    end

    // monitor: compare segments at their handshake
    always @(negedge clk) begin
        if (!rst && mem_req) req_cnt++;
        if (!rst && seg_valid && seg_ready) begin
            seg_cnt++;
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected segment", {2'b0, seg_addr, seg_len, seg_csum,
                      seg_prio, seg_force, seg_pmap, seg_sop, seg_eop}, 64'd0);
            end else begin
                logic [61:0] e;
                logic [61:0] g;
                e = expq.pop_front();
                g = {seg_addr, seg_len, seg_csum, seg_prio, seg_force,
                     seg_pmap, seg_sop, seg_eop};
                check(g == e, "R3 R4 R11 segment fields", {2'b0, g}, {2'b0, e});
            end
        end
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] bufp,
                            input logic [31:0] cfg0, input logic [31:0] cfg1,
                            input bit expect_it);
        mem[a[11:2]]       = bufp;
        mem[a[11:2] + 1]   = cfg0;
        mem[a[11:2] + 2]   = cfg1;
        mem[a[11:2] + 3]   = 32'h0;
        if (expect_it)
            expq.push_back({bufp, cfg0[15:0], cfg0[18:16], cfg0[22:20], cfg0[26],
                            cfg1[21:17], cfg0[29], cfg0[28]});
    endtask

    task automatic pulse_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 40) begin
            @(negedge clk);
            if (!mem_req && !seg_valid) quiet++;
            else quiet = 0;
        end
    endtask

    function automatic logic [31:0] cfg(input logic [15:0] len, input bit own,
                                        input bit wrap, input bit first, input bit last,
                                        input logic [2:0] csum, input logic [2:0] prio,
                                        input bit frc);
        return {own, wrap, first, last, 1'b0, frc, 2'b00, 1'b0, prio, 1'b0, csum, len};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int base_cnt;
        logic [31:0] c0, c1, c2, c3;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h8000_0000;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_req && !seg_valid, "R1 reset state", {62'd0, mem_req, seg_valid}, 64'd0);

        // ring A at 0x100, four slots, last slot wraps
        ring_base = 32'h0000_0105;   // unaligned on purpose (R7 rounding)
        @(negedge clk) ring_init = 1'b1;
        @(negedge clk) ring_init = 1'b0;
        c0 = cfg(16'd64,   1'b0, 1'b0, 1'b1, 1'b1, 3'b011, 3'd5, 1'b0);
        c1 = cfg(16'd1500, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 3'd2, 1'b1);
        c2 = cfg(16'd200,  1'b0, 1'b0, 1'b0, 1'b1, 3'b110, 3'd7, 1'b0);
        c3 = cfg(16'd0,    1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 3'd0, 1'b0);
        put_desc(32'h100, 32'h1000_0000, c0, 32'h0000_0002, 1'b1);
        put_desc(32'h120, 32'h2000_0040, c1, 32'h0020_0000, 1'b1);
        put_desc(32'h140, 32'h3000_0080, c2, 32'h00A0_0000, 1'b1);
        put_desc(32'h160, 32'hDEAD_0000, c3, 32'h0, 1'b0);
        pulse_kick();
        wait_idle();
        check(expq.size() == 0, "R3 R10 all segments delivered", 64'(expq.size()), 64'd0);
        check(seg_cnt == 3, "R4 multi-segment frame count", 64'(seg_cnt), 64'd3);
        check(mem[32'h104 >> 2] == (c0 | 32'h8000_0000), "R5 write-back slot0",
              64'(mem[32'h104 >> 2]), 64'(c0 | 32'h8000_0000));
        check(mem[32'h124 >> 2] == (c1 | 32'h8000_0000), "R5 write-back slot1",
              64'(mem[32'h124 >> 2]), 64'(c1 | 32'h8000_0000));
        check(mem[32'h144 >> 2] == (c2 | 32'h8000_0000), "R5 write-back slot2",
              64'(mem[32'h144 >> 2]), 64'(c2 | 32'h8000_0000));
        check(mem[32'h164 >> 2] == c3, "R2 software-owned slot untouched",
              64'(mem[32'h164 >> 2]), 64'(c3));

        // wrap: slot3 (end of ring) then slot0, stop at slot1
        c3 = cfg(16'd90, 1'b0, 1'b1, 1'b1, 1'b1, 3'b101, 3'd1, 1'b0);
        put_desc(32'h160, 32'h4000_0100, c3, 32'h0004_0000, 1'b1);
        c0 = cfg(16'd77, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001, 3'd3, 1'b1);
        put_desc(32'h100, 32'h5000_0000, c0, 32'h0008_0000, 1'b1);
        pulse_kick();
        wait_idle();
        check(expq.size() == 0, "R6 wrap to ring base", 64'(expq.size()), 64'd0);
        check(seg_cnt == 5, "R6 segment count after wrap", 64'(seg_cnt), 64'd5);
        check(mem[32'h164 >> 2] == (c3 | 32'h8000_0000), "R5 R6 write-back of wrap slot",
              64'(mem[32'h164 >> 2]), 64'(c3 | 32'h8000_0000));

        // ring_init moves to a new ring at 0x200; old slot1 must not be fetched
        put_desc(32'h120, 32'h6666_0000, cfg(16'd5, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0),
                 32'h0, 1'b0);
        ring_base = 32'h0000_0200;
        @(negedge clk) ring_init = 1'b1;
        @(negedge clk) ring_init = 1'b0;
        put_desc(32'h200, 32'h7000_0000, cfg(16'd128, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 3'd4, 1'b0),
                 32'h003E_0000, 1'b1);
        put_desc(32'h220, 32'h0, cfg(16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0),
                 32'h0, 1'b0);
        pulse_kick();
        wait_idle();
        check(expq.size() == 0, "R7 new ring fetched", 64'(expq.size()), 64'd0);
        check(mem[32'h124 >> 2][31] == 1'b0, "R7 old ring not touched",
              64'(mem[32'h124 >> 2][31]), 64'd0);

        // suspend holds a kick; release starts without a new kick
        suspend = 1'b1;
        put_desc(32'h220, 32'h8000_0040, cfg(16'd300, 1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 3'd6, 1'b0),
                 32'h0012_0000, 1'b1);
        base_cnt = req_cnt;
        pulse_kick();
        repeat (50) @(negedge clk);
        check(req_cnt == base_cnt, "R8 no fetch while suspended", 64'(req_cnt - base_cnt), 64'd0);
        check(seg_cnt == 6, "R8 no segment while suspended", 64'(seg_cnt), 64'd6);
        suspend = 1'b0;
        wait_idle();
        check(seg_cnt == 7 && expq.size() == 0, "R9 held kick acted on",
              64'(seg_cnt), 64'd7);

        // suspend mid-chain: current descriptor finishes, next is held
        c1 = cfg(16'd44, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0);
        put_desc(32'h200, 32'h9000_0000, cfg(16'd33, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1, 1'b0),
                 32'h0002_0000, 1'b1);
        put_desc(32'h220, 32'hA000_0000, c1, 32'h0000_0000, 1'b1);
        pulse_kick();
        while (!(seg_valid && seg_ready)) @(negedge clk);
        suspend = 1'b1;
        wait_idle();
        check(seg_cnt == 8, "R8 halt after current descriptor", 64'(seg_cnt), 64'd8);
        check(mem[32'h204 >> 2][31] == 1'b1, "R8 current write-back done",
              64'(mem[32'h204 >> 2][31]), 64'd1);
        check(mem[32'h224 >> 2] == c1, "R8 next descriptor untouched",
              64'(mem[32'h224 >> 2]), 64'(c1));
        suspend = 1'b0;
        wait_idle();
        check(seg_cnt == 8, "R9 no restart without kick", 64'(seg_cnt), 64'd8);
        pulse_kick();
        wait_idle();
        check(seg_cnt == 9 && expq.size() == 0, "R9 kick resumes walk", 64'(seg_cnt), 64'd9);
        check(mem[32'h224 >> 2] == (c1 | 32'h8000_0000), "R5 final write-back",
              64'(mem[32'h224 >> 2]), 64'(c1 | 32'h8000_0000));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule